// File: doc/BRIEF.md
# Keyboard Scancode to Digit Filter

This block sits behind a keyboard byte receiver and in front of a digit shift register. It receives finished scancode bytes in scan code set 2. Each byte comes with a strobe that is high for one clock cycle. Every key press becomes a 4-bit code: the ten digit keys on the main row and on the keypad give their value 0 to 9, and any other key gives the dash code 0xB. With the code comes a one-cycle shift pulse that pushes the code into the display register.

Release sequences never reach the display. A small state machine tracks the release prefix 0xF0 and the extended prefix 0xE0. It has four states:
- `ST_IDLE`: no prefix pending.
- `ST_EXT`: the extended prefix has been seen.
- `ST_REL`: the release prefix has been seen.
- `ST_EXT_REL`: the extended prefix and then the release prefix have been seen.

The transitions, named as they are in the RTL:
- **go_ext**: `ST_IDLE` to `ST_EXT` on 0xE0.
- **go_rel**: `ST_IDLE` to `ST_REL` on 0xF0.
- **ext_rel**: `ST_EXT` to `ST_EXT_REL` on 0xF0.
- **rel_ext**: `ST_REL` to `ST_EXT_REL` on 0xE0.
- **hold**: a repeated prefix keeps the current pending state.
- **emit**: a non-prefix byte in `ST_IDLE` or `ST_EXT` produces a press and returns to `ST_IDLE`.
- **drop**: a non-prefix byte in `ST_REL` or `ST_EXT_REL` is discarded and returns to `ST_IDLE`.

Both outputs are registered, so every result appears one clock after the strobed byte.

Top module: `kbd_digit_filter`

## Requirements
- R1: A byte presented while `scan_stb_i` is low has no effect: `digit_shift_o` stays low, `digit_code_o` keeps its value, and the decoder state does not change.
- R2: A strobed main-row digit make code in the idle state gives `digit_code_o` equal to its digit. The codes for digits 0 to 9 are 0x45, 0x16, 0x1E, 0x26, 0x25, 0x2E, 0x36, 0x3D, 0x3E and 0x46.
- R3: A strobed keypad digit make code in the idle state gives `digit_code_o` equal to its digit. The codes for digits 0 to 9 are 0x70, 0x69, 0x72, 0x7A, 0x6B, 0x73, 0x74, 0x6C, 0x75 and 0x7D.
- R4: Any other strobed make code in the idle state gives the dash code 0xB.
- R5: Each accepted press raises `digit_shift_o` for exactly one cycle, the cycle after the strobe, with `digit_code_o` valid in that same cycle.
- R6: A 0xF0 byte produces no shift. The next non-prefix byte is discarded with no shift, after which the decoder is idle again.
- R7: A make code that follows 0xE0 gives the dash code 0xB with a shift, even when the byte is a digit code.
- R8: The sequence 0xE0, 0xF0, then a code produces no shift at all.
- R9: Repeated make codes of a held key each give their own shift pulse.
- R10: A synchronous active-high reset returns the decoder to idle, holds `digit_shift_o` low and clears `digit_code_o` to 0.
- R11: A prefix byte repeated while a prefix is pending keeps that prefix pending. 0xE0 seen after 0xF0 turns a pending release into an extended release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| scan_byte_i | input | 8 | Completed scancode byte |
| scan_stb_i | input | 1 | One-cycle strobe marking a completed byte |
| digit_code_o | output | 4 | Digit 0 to 9 or dash 0xB; held between shifts |
| digit_shift_o | output | 1 | One-cycle pulse per accepted key press |

## Verification
Every result is due exactly one rising edge after the edge that samples the strobed byte, because the path has a single output register. The bench drives each byte on a falling edge and removes the strobe one falling edge later. It samples shift and code at that second falling edge, and samples again one cycle later to confirm that the pulse has ended. For bytes that must produce nothing, the same sample point shows the shift low and the code unchanged. A press that follows confirms that the decoder is back in idle.

// File: rtl/kbd_digit_pkg.sv
package kbd_digit_pkg;

    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 4;
    localparam int N_DIGITS = 10;

    localparam logic [BYTE_W-1:0] PFX_REL = 8'hF0;
    localparam logic [BYTE_W-1:0] PFX_EXT = 8'hE0;
    localparam logic [CODE_W-1:0] DASH    = 4'hB;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_EXT     = 2'd1,
        ST_REL     = 2'd2,
        ST_EXT_REL = 2'd3
    } kd_state_t;

    // make codes indexed by digit value
    localparam logic [BYTE_W-1:0] MAIN_ROW [N_DIGITS] = '{
        8'h45, 8'h16, 8'h1E, 8'h26, 8'h25, 8'h2E, 8'h36, 8'h3D, 8'h3E, 8'h46
    };
    localparam logic [BYTE_W-1:0] KEYPAD [N_DIGITS] = '{
        8'h70, 8'h69, 8'h72, 8'h7A, 8'h6B, 8'h73, 8'h74, 8'h6C, 8'h75, 8'h7D
    };

endpackage

// File: rtl/kbd_digit_map.sv
module kbd_digit_map
    import kbd_digit_pkg::*;
#(
    parameter bit KEYPAD_EN = 1'b1
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic              hit_o,
    output logic [CODE_W-1:0] val_o
);

    logic              row_hit;
    logic [CODE_W-1:0] row_val;
    logic              kp_hit;
    logic [CODE_W-1:0] kp_val;

    always_comb begin
        row_hit = 1'b0;
        row_val = DASH;
        for (int i = 0; i < N_DIGITS; i++) begin
            if (byte_i == MAIN_ROW[i]) begin
                row_hit = 1'b1;
                row_val = CODE_W'(i);
            end
        end
    end

    generate
        if (KEYPAD_EN) begin : g_keypad
            always_comb begin
                kp_hit = 1'b0;
                kp_val = DASH;
                for (int i = 0; i < N_DIGITS; i++) begin
                    if (byte_i == KEYPAD[i]) begin
                        kp_hit = 1'b1;
                        kp_val = CODE_W'(i);
                    end
                end
            end
        end else begin : g_no_keypad
            assign kp_hit = 1'b0;
            assign kp_val = DASH;
        end
    endgenerate

    assign hit_o = row_hit | kp_hit;
    assign val_o = row_hit ? row_val : (kp_hit ? kp_val : DASH);

endmodule

// File: rtl/kbd_prefix_fsm.sv
module kbd_prefix_fsm
    import kbd_digit_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              stb_i,
    output logic              emit_o,
    output logic              ext_o
);

    kd_state_t state_q;
    kd_state_t state_d;
    logic      is_rel;
    logic      is_ext;

    assign is_rel = (byte_i == PFX_REL);
    assign is_ext = (byte_i == PFX_EXT);

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        emit_o  = 1'b0;
        ext_o   = 1'b0;
        if (stb_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (is_ext)      state_d = ST_EXT;      // go_ext
                    else if (is_rel) state_d = ST_REL;      // go_rel
                    else             emit_o  = 1'b1;        // emit
                end
                ST_EXT: begin
                    if (is_ext)      state_d = ST_EXT;      // hold
                    else if (is_rel) state_d = ST_EXT_REL;  // ext_rel
                    else begin                              // emit
                        emit_o  = 1'b1;
                        ext_o   = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                ST_REL: begin
                    if (is_rel)      state_d = ST_REL;      // hold
                    else if (is_ext) state_d = ST_EXT_REL;  // rel_ext
                    else             state_d = ST_IDLE;     // drop
                end
                ST_EXT_REL: begin
                    if (is_rel || is_ext) state_d = ST_EXT_REL; // hold
                    else                  state_d = ST_IDLE;    // drop
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/kbd_out_reg.sv
module kbd_out_reg
    import kbd_digit_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              emit_i,
    input  logic              ext_i,
    input  logic              hit_i,
    input  logic [CODE_W-1:0] val_i,
    output logic [CODE_W-1:0] code_o,
    output logic              shift_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shift_o <= 1'b0;
            code_o  <= '0;
        end else begin
            shift_o <= emit_i;
            if (emit_i) begin
                code_o <= (ext_i || !hit_i) ? DASH : val_i;
            end
        end
    end

endmodule

// File: rtl/kbd_digit_filter.sv
module kbd_digit_filter
    import kbd_digit_pkg::*;
#(
    parameter bit KEYPAD_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [BYTE_W-1:0] scan_byte_i,
    input  logic              scan_stb_i,
    output logic [CODE_W-1:0] digit_code_o,
    output logic              digit_shift_o
);

    logic              emit;
    logic              ext;
    logic              hit;
    logic [CODE_W-1:0] val;

    kbd_prefix_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .byte_i (scan_byte_i),
        .stb_i  (scan_stb_i),
        .emit_o (emit),
        .ext_o  (ext)
    );

    kbd_digit_map #(.KEYPAD_EN(KEYPAD_EN)) u_map (
        .byte_i (scan_byte_i),
        .hit_o  (hit),
        .val_o  (val)
    );

    kbd_out_reg u_out (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .emit_i  (emit),
        .ext_i   (ext),
        .hit_i   (hit),
        .val_i   (val),
        .code_o  (digit_code_o),
        .shift_o (digit_shift_o)
    );

endmodule

// File: rtl/kbd_digit_filter_chk.sv
module kbd_digit_filter_chk
    import kbd_digit_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic [BYTE_W-1:0] scan_byte_i,
    input logic              scan_stb_i,
    input logic [CODE_W-1:0] digit_code_o,
    input logic              digit_shift_o
);

    AST_NO_SHIFT_WITHOUT_STB: assert property (@(posedge clk_i) disable iff (rst_i)
        !scan_stb_i |=> !digit_shift_o); // R1

    AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!digit_shift_o && !$past(rst_i)) |-> $stable(digit_code_o)); // R1

    AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        digit_shift_o |-> (digit_code_o <= 4'd9 || digit_code_o == DASH)); // R4

    AST_SHIFT_FROM_STB: assert property (@(posedge clk_i) disable iff (rst_i)
        digit_shift_o |-> $past(scan_stb_i)); // R5

    AST_REL_PREFIX_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (scan_stb_i && scan_byte_i == PFX_REL) |=> !digit_shift_o); // R6

    AST_EXT_PREFIX_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (scan_stb_i && scan_byte_i == PFX_EXT) |=> !digit_shift_o); // R7

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        $past(rst_i) |-> !digit_shift_o); // R10

endmodule

bind kbd_digit_filter kbd_digit_filter_chk u_chk (.*);

// File: tb/kbd_digit_filter_bench.sv
module kbd_digit_filter_bench;

    logic       clk;
    logic       rst;
    logic [7:0] sbyte;
    logic       stb;
    logic [3:0] code;
    logic       shift;

    int checks = 0;
    int errors = 0;
    logic [3:0] last_code = 4'h0;
    bit done = 0;

    kbd_digit_filter u_kbd_digit_filter (
        .clk_i         (clk),
        .rst_i         (rst),
        .scan_byte_i   (sbyte),
        .scan_stb_i    (stb),
        .digit_code_o  (code),
        .digit_shift_o (shift)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [7:0] row_code(int d);
        case (d)
            0: return 8'h45; 1: return 8'h16; 2: return 8'h1E; 3: return 8'h26;
            4: return 8'h25; 5: return 8'h2E; 6: return 8'h36; 7: return 8'h3D;
            8: return 8'h3E; default: return 8'h46;
        endcase
    endfunction

    function automatic logic [7:0] pad_code(int d);
        case (d)
            0: return 8'h70; 1: return 8'h69; 2: return 8'h72; 3: return 8'h7A;
            4: return 8'h6B; 5: return 8'h73; 6: return 8'h74; 7: return 8'h6C;
            8: return 8'h75; default: return 8'h7D;
        endcase
    endfunction

    task automatic check(string req, logic exp_shift, logic [3:0] exp_code);
        checks++;
        if (shift !== exp_shift || code !== exp_code) begin
            errors++;
            $display("FAIL %s: shift=%0b code=%h expected shift=%0b code=%h",
                     req, shift, code, exp_shift, exp_code);
        end
    endtask

    // drive one strobed byte; sample one cycle later
    task automatic send(logic [7:0] b, logic exp_shift, logic [3:0] exp_code, string req);
        @(negedge clk);
        sbyte = b;
        stb   = 1'b1;
        @(negedge clk);
        stb   = 1'b0;
        if (exp_shift) last_code = exp_code;
        check(req, exp_shift, exp_shift ? exp_code : last_code);
    endtask

    task automatic idle_check(string req);
        @(negedge clk);
        check(req, 1'b0, last_code);
    endtask

    task automatic t_reset;
        rst = 1'b1; stb = 1'b0; sbyte = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        last_code = 4'h0;
        check("R10 reset state", 1'b0, 4'h0);
    endtask

    task automatic t_main_row;
        for (int d = 0; d < 10; d++) send(row_code(d), 1'b1, 4'(d), "R2 main row digit");
        idle_check("R5 pulse ends");
    endtask

    task automatic t_keypad;
        for (int d = 9; d >= 0; d--) send(pad_code(d), 1'b1, 4'(d), "R3 keypad digit");
    endtask

    task automatic t_other;
        send(8'h1C, 1'b1, 4'hB, "R4 letter key dash");
        send(8'h5A, 1'b1, 4'hB, "R4 enter key dash");
        send(8'h00, 1'b1, 4'hB, "R4 zero byte dash");
        idle_check("R5 single pulse");
    endtask

    task automatic t_release;
        send(8'h2E, 1'b1, 4'd5, "R5 press before release");
        send(8'hF0, 1'b0, 4'h0, "R6 release prefix silent");
        send(8'h2E, 1'b0, 4'h0, "R6 released key dropped");
        send(8'h16, 1'b1, 4'd1, "R6 idle after release");
    endtask

    task automatic t_extended;
        send(8'hE0, 1'b0, 4'h0, "R7 ext prefix silent");
        send(8'h70, 1'b1, 4'hB, "R7 extended digit gives dash");
        send(8'h26, 1'b1, 4'd3, "R7 ext flag cleared");
    endtask

    task automatic t_ext_release;
        send(8'hE0, 1'b0, 4'h0, "R8 ext prefix");
        send(8'hF0, 1'b0, 4'h0, "R8 ext release prefix");
        send(8'h75, 1'b0, 4'h0, "R8 ext released key dropped");
        send(8'h3E, 1'b1, 4'd8, "R8 idle after ext release");
    endtask

    task automatic t_typematic;
        for (int k = 0; k < 4; k++) send(8'h36, 1'b1, 4'd6, "R9 repeat pulse");
        idle_check("R9 no extra pulse");
    endtask

    task automatic t_no_strobe;
        @(negedge clk);
        sbyte = 8'h45;
        stb   = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check("R1 unstrobed byte ignored", 1'b0, last_code);
        end
        sbyte = 8'hF0;
        repeat (2) @(negedge clk);
        check("R1 unstrobed prefix ignored", 1'b0, last_code);
        send(8'h1E, 1'b1, 4'd2, "R1 state unchanged");
    endtask

    task automatic t_prefix_repeat;
        send(8'hF0, 1'b0, 4'h0, "R11 release prefix");
        send(8'hF0, 1'b0, 4'h0, "R11 repeated release prefix");
        send(8'h25, 1'b0, 4'h0, "R11 still dropped");
        send(8'hF0, 1'b0, 4'h0, "R11 release then ext");
        send(8'hE0, 1'b0, 4'h0, "R11 ext after release");
        send(8'h46, 1'b0, 4'h0, "R11 ext release dropped");
        send(8'hE0, 1'b0, 4'h0, "R11 ext prefix");
        send(8'hE0, 1'b0, 4'h0, "R11 repeated ext prefix");
        send(8'h45, 1'b1, 4'hB, "R11 ext kept gives dash");
    endtask

    task automatic t_reset_mid;
        send(8'hF0, 1'b0, 4'h0, "R10 arm release");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        last_code = 4'h0;
        check("R10 reset clears code", 1'b0, 4'h0);
        send(8'h3D, 1'b1, 4'd7, "R10 idle after reset");
    endtask

    initial begin
        t_reset();
        t_main_row();
        t_keypad();
        t_other();
        t_release();
        t_extended();
        t_ext_release();
        t_typematic();
        t_no_strobe();
        t_prefix_repeat();
        t_reset_mid();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: done=0 expected done=1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule